// File: doc/BRIEF.md
# Input Period Measurement Toggle Gate

This block measures the time between successive valid edges on an external interrupt pin. The pin is resynchronised into the clock domain. Each valid edge flips a gate that either passes or blocks a count-source strobe. The strobes that pass drive an 8-bit down counter, so the counter's progress while the gate is open gives the length of one input period in units of the count source.

Turning the measurement function on opens the gate and preloads the counter. The next valid edge closes the gate, raises a one-cycle completion pulse and freezes the counter so the result can be read. The edge after that reopens the gate and preloads the counter again, and the pattern repeats.

Clearing either the interrupt-input enable or the measurement enable shuts the gate and stops all toggling. The measured value needs no back-pressure: it stays on the count output until the gate next opens, so a consumer may read it at any time in that window.

Top module: `period_gate`

## Requirements
- R1: While rst_n is low at a clock edge, meas_count becomes 0, meas_done becomes 0 and gate_open takes the value meas_en AND int_en.
- R2: gated_strobe equals src_strobe when gate_open is 1 and both enables are 1; otherwise gated_strobe is 0.
- R3: When meas_en AND int_en goes from 0 to 1, gate_open becomes 1 at the next clock edge and meas_count is loaded with 255 at the same edge.
- R4: A valid edge while the gate is open closes the gate. meas_done is 1 for exactly the one cycle in which gate_open first reads 0.
- R5: A valid edge while the gate is closed and the function is on reopens the gate and reloads meas_count with 255.
- R6: With rise_sel = 1 only 0-to-1 pin transitions are valid edges; with rise_sel = 0 only 1-to-0 transitions are. A transition of the other direction leaves gate_open unchanged.
- R7: With int_en = 0 the gate is closed from the next clock edge on, and pin transitions and strobes change neither gate_open nor meas_count.
- R8: With meas_en = 0 the gate is closed from the next clock edge on, and strobes do not change meas_count.
- R9: Each clock edge with gated_strobe high lowers meas_count by one, wrapping from 0 to 255. While the gate stays closed, meas_count holds.
- R10: The pin passes through two synchroniser flops. A pin transition first sampled at clock edge k changes gate_open at edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_pin | input | 1 | Asynchronous external interrupt pin |
| rise_sel | input | 1 | Valid edge polarity: 1 rising, 0 falling |
| meas_en | input | 1 | Period measurement enable |
| int_en | input | 1 | Interrupt-input enable |
| src_strobe | input | 1 | Count-source strobe, one cycle per count |
| gated_strobe | output | 1 | Strobe passed through the gate |
| gate_open | output | 1 | Current gate state |
| meas_done | output | 1 | One-cycle pulse when the gate closes |
| meas_count | output | 8 | Down-counter value, held while the gate is closed |

## Verification
Two conditions are the hardest to reach from the ports. One is a valid edge that arrives while strobes keep coming and must freeze the count at exactly the right value. The other is a transition of the wrong polarity, which has to leave the gate alone even though it passes through the same synchroniser. The bench changes the pin only on falling clock edges, waits out the synchroniser latency, and then sends a known number of strobes. Each value the count freezes at can therefore be worked out in advance. The pin is also toggled while each enable is off, and a full 256-strobe wrap is run to check that the held value and the preload are separate.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic {POL_FALL = 1'b0, POL_RISE = 1'b1} pol_e;

  function automatic logic pick_edge(pol_e pol, logic rise, logic fall);
    return (pol == POL_RISE) ? rise : fall;
  endfunction
endpackage

// File: rtl/pg_edge_sync.sv
module pg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic rise_sel,
  output logic valid_edge
);
  import pg_pkg::*;
  localparam int LAST = STAGES - 1;

  logic [STAGES:0] shreg;
  logic            rise_w;
  logic            fall_w;

  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], pin_async};
  end

  assign rise_w     = shreg[LAST] & ~shreg[STAGES];
  assign fall_w     = ~shreg[LAST] & shreg[STAGES];
  assign valid_edge = pick_edge(pol_e'(rise_sel), rise_w, fall_w);
endmodule

// File: rtl/pg_gate_ctrl.sv
module pg_gate_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic valid_edge,
  output logic gate_q,
  output logic load,
  output logic done_q
);
  logic act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= active;
      act_q  <= active;
      done_q <= 1'b0;
    end else begin
      act_q  <= active;
      done_q <= 1'b0;
      if (!active) begin
        gate_q <= 1'b0;
      end else if (!act_q) begin
        gate_q <= 1'b1;
      end else if (valid_edge) begin
        gate_q <= ~gate_q;
        done_q <= gate_q;
      end
    end
  end

  assign load = active & (~act_q | (valid_edge & ~gate_q));
endmodule

// File: rtl/pg_down_cnt.sv
module pg_down_cnt #(
  parameter int              W      = 8,
  parameter logic [W-1:0]    PRESET = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= PRESET;
    else if (dec)  count <= count - W'(1);
  end
endmodule

// File: rtl/period_gate.sv
module period_gate #(
  parameter int                 CNT_W       = 8,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0]   PRESET      = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_pin,
  input  logic             rise_sel,
  input  logic             meas_en,
  input  logic             int_en,
  input  logic             src_strobe,
  output logic             gated_strobe,
  output logic             gate_open,
  output logic             meas_done,
  output logic [CNT_W-1:0] meas_count
);
  logic active;
  logic valid_edge;
  logic load;

  assign active = meas_en & int_en;

  pg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_async  (int_pin),
    .rise_sel   (rise_sel),
    .valid_edge (valid_edge)
  );

  pg_gate_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .valid_edge (valid_edge),
    .gate_q     (gate_open),
    .load       (load),
    .done_q     (meas_done)
  );

  assign gated_strobe = src_strobe & gate_open & active;

  pg_down_cnt #(.W(CNT_W), .PRESET(PRESET)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .dec   (gated_strobe),
    .count (meas_count)
  );
endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
  parameter int               CNT_W  = 8,
  parameter logic [CNT_W-1:0] PRESET = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             meas_en,
  input logic             int_en,
  input logic             src_strobe,
  input logic             gated_strobe,
  input logic             gate_open,
  input logic             meas_done,
  input logic [CNT_W-1:0] meas_count
);
  p_gate_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gated_strobe |-> (src_strobe && gate_open));

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |=> !meas_done);

  p_done_on_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |-> (!gate_open && $past(gate_open)));

  p_open_preset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_open) |-> (meas_count == PRESET));

  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |=> !gate_open);

  p_meas_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_en |=> !gate_open);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_open && !$past(gate_open)) |-> $stable(meas_count));

  p_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gated_strobe |=> (meas_count == $past(meas_count) - CNT_W'(1)));
endmodule

bind period_gate pg_checker #(.CNT_W(CNT_W), .PRESET(PRESET)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .meas_en      (meas_en),
  .int_en       (int_en),
  .src_strobe   (src_strobe),
  .gated_strobe (gated_strobe),
  .gate_open    (gate_open),
  .meas_done    (meas_done),
  .meas_count   (meas_count)
);

// File: tb/period_gate_bench.sv
`timescale 1ns/1ps
module period_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       int_pin = 1'b0;
  logic       rise_sel = 1'b1;
  logic       meas_en = 1'b0;
  logic       int_en = 1'b0;
  logic       src_strobe = 1'b0;
  logic       gated_strobe;
  logic       gate_open;
  logic       meas_done;
  logic [7:0] meas_count;

  int checks = 0;
  int failures = 0;
  int done_cnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  period_gate u_period_gate (
    .clk(clk), .rst_n(rst_n), .int_pin(int_pin), .rise_sel(rise_sel),
    .meas_en(meas_en), .int_en(int_en), .src_strobe(src_strobe),
    .gated_strobe(gated_strobe), .gate_open(gate_open),
    .meas_done(meas_done), .meas_count(meas_count)
  );

  always @(posedge clk) if (meas_done) done_cnt <= done_cnt + 1;

  typedef struct packed {
    logic       pin;
    logic [3:0] n;
    logic       gate;
    logic [7:0] cnt;
    logic [1:0] dones;
  } row_t;

  // Rising-edge mode, gate opened with count 255 before the walk.
  localparam row_t ROWS [8] = '{
    '{1'b0, 4'd5, 1'b1, 8'd250, 2'd0},
    '{1'b1, 4'd3, 1'b0, 8'd250, 2'd1},
    '{1'b0, 4'd2, 1'b0, 8'd250, 2'd1},
    '{1'b1, 4'd4, 1'b1, 8'd251, 2'd1},
    '{1'b0, 4'd1, 1'b1, 8'd250, 2'd1},
    '{1'b1, 4'd2, 1'b0, 8'd250, 2'd2},
    '{1'b0, 4'd0, 1'b0, 8'd250, 2'd2},
    '{1'b1, 4'd0, 1'b1, 8'd255, 2'd2}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobes(input int n);
    src_strobe = 1'b1;
    repeat (n) tick();
    src_strobe = 1'b0;
    tick();
  endtask

  task automatic set_pin(input logic v);
    int_pin = v;
    repeat (4) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1: reset with function off
    check(gate_open == 1'b0, "R1 gate", gate_open, 0);
    check(meas_count == 8'd0, "R1 count", meas_count, 0);
    check(meas_done == 1'b0, "R1 done", meas_done, 0);
    rst_n = 1'b1;
    tick();
    meas_en = 1'b1; int_en = 1'b1;
    tick();
    // R3: enabling opens and preloads
    check(gate_open == 1'b1, "R3 gate", gate_open, 1);
    check(meas_count == 8'd255, "R3 count", meas_count, 255);

    // Table walk: R4 R5 R6 R9
    for (int i = 0; i < 8; i++) begin
      set_pin(ROWS[i].pin);
      strobes(int'(ROWS[i].n));
      check(gate_open == ROWS[i].gate, "R5 walk gate", gate_open, ROWS[i].gate);
      check(meas_count == ROWS[i].cnt, "R9 walk count", meas_count, ROWS[i].cnt);
      check(done_cnt == int'(ROWS[i].dones), "R4 walk done", done_cnt, ROWS[i].dones);
    end

    // R10 latency and R4 pulse width; gate open, pin high
    set_pin(1'b0);
    int_pin = 1'b1;
    tick(); tick();
    check(gate_open == 1'b1, "R10 before", gate_open, 1);
    tick();
    check(gate_open == 1'b0, "R10 after", gate_open, 0);
    check(meas_done == 1'b1, "R4 pulse", meas_done, 1);
    tick();
    check(meas_done == 1'b0, "R4 pulse end", meas_done, 0);

    // R9 wrap after reopening
    set_pin(1'b0);
    set_pin(1'b1);
    check(meas_count == 8'd255, "R5 reload", meas_count, 255);
    strobes(255);
    check(meas_count == 8'd0, "R9 zero", meas_count, 0);
    strobes(1);
    check(meas_count == 8'd255, "R9 wrap", meas_count, 255);

    // R2 gating visible combinationally
    src_strobe = 1'b1;
    #1;
    check(gated_strobe == 1'b1, "R2 pass", gated_strobe, 1);
    tick();
    src_strobe = 1'b0;
    check(meas_count == 8'd254, "R2 count", meas_count, 254);

    // R7 interrupt input disabled
    int_en = 1'b0;
    tick();
    check(gate_open == 1'b0, "R7 closed", gate_open, 0);
    set_pin(1'b0);
    set_pin(1'b1);
    src_strobe = 1'b1;
    #1;
    check(gated_strobe == 1'b0, "R7 strobe blocked", gated_strobe, 0);
    tick(); tick();
    src_strobe = 1'b0;
    set_pin(1'b0);
    check(gate_open == 1'b0, "R7 no toggle", gate_open, 0);
    check(meas_count == 8'd254, "R7 hold", meas_count, 254);
    int_en = 1'b1;
    tick();
    check(gate_open == 1'b1 && meas_count == 8'd255, "R3 reenable", meas_count, 255);

    // R8 measurement disabled
    meas_en = 1'b0;
    tick();
    check(gate_open == 1'b0, "R8 closed", gate_open, 0);
    strobes(2);
    check(meas_count == 8'd255, "R8 hold", meas_count, 255);
    meas_en = 1'b1;
    tick();

    // R6 falling polarity
    rise_sel = 1'b0;
    set_pin(1'b1);
    check(gate_open == 1'b1, "R6 rise ignored", gate_open, 1);
    set_pin(1'b0);
    check(gate_open == 1'b0, "R6 fall closes", gate_open, 0);

    // R1 reset with function on
    rst_n = 1'b0;
    tick(); tick();
    check(gate_open == 1'b1, "R1 gate on", gate_open, 1);
    check(meas_count == 8'd0, "R1 count on", meas_count, 0);
    check(meas_done == 1'b0, "R1 done on", meas_done, 0);
    rst_n = 1'b1;
    tick();
    strobes(1);
    check(meas_count == 8'd255, "R9 wrap from reset", meas_count, 255);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule